// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It walks a two-level page table stored in ordinary memory. A requester presents a logical address together with a read or write flag. The walker then fetches the outer table entry and, from it, the inner table entry. These are two dependent reads on a simple memory read port whose latency can vary. The walker answers with either a translated physical address or a 2-bit trap code.

Two configuration inputs frame every walk:

- **Table root** gives the byte address where the outer table starts.
- **Length bound** gives how many outer entries are legal.

The block checks, in this order:

1. the length bound,
2. the valid bit of each entry,
3. the writable bit of the final entry.

It reports the first check that fails instead of a translation. It holds no translation cache and never writes to the table.

Top module: `pgw_walker`

## Requirements
- R1: After reset the walker is idle. `req_ready_o` is 1, `mem_req_valid_o` is 0 and `rsp_done_o` is 0.
- R2: The logical address splits, from most to least significant, into a 12-bit outer index (bits 31:20), a 10-bit inner index (bits 19:10) and a 10-bit offset (bits 9:0). The first read goes to `ptbr_i + outer*4`, and it is issued only after the request is accepted.
- R3: If the outer index is greater than or equal to `ptlr_i`, the walk ends with fault code 0. No memory read is issued. The length check comes before every other check.
- R4: Each table entry is 32 bits:
  - bit 0 is valid;
  - bit 1 is writable;
  - bits 31:10 are a base.
  The second read goes to `{outer_entry[31:10], 10'b0} + inner*4`.
- R5: An outer entry with bit 0 clear ends the walk with fault code 1, after exactly one memory read.
- R6: A final entry with bit 0 clear ends the walk with fault code 2, after two reads. This holds even for a write access.
- R7: A write to a final entry with bit 1 clear ends with fault code 3. A read of the same entry translates normally.
- R8: A successful walk returns `rsp_paddr_o = {final_entry[31:10], offset}` with `rsp_fault_o` 0. A faulting walk returns `rsp_fault_o` 1, and `rsp_paddr_o` is 0 in that case. `rsp_done_o` is high for exactly one cycle per walk, and `rsp_fault_o` is never high without it.
- R9: Memory timing is flexible in two ways:
  - A memory request is held, with a stable address, until `mem_req_ready_i`.
  - The walker waits any number of cycles for `mem_rsp_valid_i`, which must come at least one cycle after the handshake.
- R10: A request is accepted only while idle. `req_ready_o` is 0 from acceptance until `rsp_done_o` has been shown, and a request presented during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptbr_i | input | 32 | Byte address of the outer table |
| ptlr_i | input | 13 | Number of legal outer entries |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle, request taken this cycle |
| req_vaddr_i | input | 32 | Logical address |
| req_write_i | input | 1 | 1 for a write access, 0 for a read |
| mem_req_valid_o | output | 1 | Table read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 32 | Byte address of the table entry |
| mem_rsp_valid_i | input | 1 | Read data returned |
| mem_rsp_data_i | input | 32 | Table entry |
| rsp_done_o | output | 1 | One-cycle walk completion |
| rsp_fault_o | output | 1 | Walk ended in a trap |
| rsp_fault_code_o | output | 2 | 0 length, 1 outer invalid, 2 inner invalid, 3 write protect |
| rsp_paddr_o | output | 32 | Physical address, 0 on a trap |

## Verification
The bench uses the following kinds of request:

- **Translations through several inner tables with different offsets.** These show that the frame base really comes from the final entry and that the offset passes through unchanged.
- **Outer indices on each side of the length bound, including a zero bound.** These separate a correct comparison from an off-by-one.
- **Entries that are invalid at each level, and a write to an invalid inner entry.** These confirm the trap order and the number of reads issued before each trap.
- **Reads and writes of the same read-only frame.** These show that protection depends on the access type.
- **Slow memory with ready stalls and long latency, plus a second request held up mid-walk.** These show that results do not depend on timing and that busy-time requests are dropped.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_RD_INNER,
    ST_DONE,
    ST_FAULT
  } walk_state_t;

  localparam logic [1:0] FLT_LENGTH    = 2'd0;
  localparam logic [1:0] FLT_OUTER_INV = 2'd1;
  localparam logic [1:0] FLT_INNER_INV = 2'd2;
  localparam logic [1:0] FLT_PROTECT   = 2'd3;

endpackage

// File: rtl/pgw_entry_decode.sv
module pgw_entry_decode #(
  parameter int ENT_W = 32,
  parameter int OFF_W = 10
) (
  input  logic [ENT_W-1:0]       entry_i,
  output logic                   valid_o,
  output logic                   writable_o,
  output logic [ENT_W-OFF_W-1:0] base_o
);
  // bit 0 valid, bit 1 writable, upper bits base; the rest are ignored
  logic unused_bits;
  assign unused_bits = ^entry_i[OFF_W-1:2];

  assign valid_o    = entry_i[0];
  assign writable_o = entry_i[1];
  assign base_o     = entry_i[ENT_W-1:OFF_W];
endmodule

// File: rtl/pgw_entry_addr.sv
module pgw_entry_addr #(
  parameter int AW = 32,
  parameter int IW = 12,
  parameter int SH = 2
) (
  input  logic [AW-1:0] base_i,
  input  logic [IW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] byte_off;
  assign byte_off = {{(AW-IW-SH){1'b0}}, idx_i, {SH{1'b0}}};
  assign addr_o   = base_i + byte_off;
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker #(
  parameter int OUT_W = 12,
  parameter int IN_W  = 10,
  parameter int OFF_W = 10,
  parameter int ENT_W = 32,
  parameter int VA_W  = OUT_W + IN_W + OFF_W,
  parameter int LEN_W = OUT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ENT_W-1:0] ptbr_i,
  input  logic [LEN_W-1:0] ptlr_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [ENT_W-1:0] mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [ENT_W-1:0] mem_rsp_data_i,
  output logic             rsp_done_o,
  output logic             rsp_fault_o,
  output logic [1:0]       rsp_fault_code_o,
  output logic [ENT_W-1:0] rsp_paddr_o
);
  import pgw_pkg::*;

  localparam int BASE_W = ENT_W - OFF_W;
  localparam int ENT_SH = $clog2(ENT_W / 8);
  localparam int LOW_W  = IN_W + OFF_W;

  walk_state_t      state_q;
  logic [LOW_W-1:0] low_q;
  logic             write_q;

  logic [OUT_W-1:0]  outer_idx;
  logic [IN_W-1:0]   inner_idx;
  logic [OFF_W-1:0]  page_off;
  logic [ENT_W-1:0]  outer_addr;
  logic [ENT_W-1:0]  inner_addr;
  logic [ENT_W-1:0]  inner_tbl;
  logic              ent_valid;
  logic              ent_writable;
  logic [BASE_W-1:0] ent_base;
  logic              len_bad;
  logic              rsp_take;

  assign outer_idx = req_vaddr_i[VA_W-1 -: OUT_W];
  assign inner_idx = low_q[OFF_W +: IN_W];
  assign page_off  = low_q[OFF_W-1:0];
  assign len_bad   = {1'b0, outer_idx} >= ptlr_i;
  assign inner_tbl = {ent_base, {OFF_W{1'b0}}};
  assign rsp_take  = !mem_req_valid_o && mem_rsp_valid_i;

  pgw_entry_addr #(.AW(ENT_W), .IW(OUT_W), .SH(ENT_SH)) u_outer_addr (
    .base_i(ptbr_i), .idx_i(outer_idx), .addr_o(outer_addr)
  );

  pgw_entry_addr #(.AW(ENT_W), .IW(IN_W), .SH(ENT_SH)) u_inner_addr (
    .base_i(inner_tbl), .idx_i(inner_idx), .addr_o(inner_addr)
  );

  pgw_entry_decode #(.ENT_W(ENT_W), .OFF_W(OFF_W)) u_decode (
    .entry_i(mem_rsp_data_i), .valid_o(ent_valid),
    .writable_o(ent_writable), .base_o(ent_base)
  );

  assign req_ready_o = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q          <= ST_IDLE;
      low_q            <= '0;
      write_q          <= 1'b0;
      mem_req_valid_o  <= 1'b0;
      mem_req_addr_o   <= '0;
      rsp_done_o       <= 1'b0;
      rsp_fault_o      <= 1'b0;
      rsp_fault_code_o <= '0;
      rsp_paddr_o      <= '0;
    end else begin
      rsp_done_o  <= 1'b0;
      rsp_fault_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            low_q   <= req_vaddr_i[LOW_W-1:0];
            write_q <= req_write_i;
            if (len_bad) begin
              state_q          <= ST_FAULT;
              rsp_done_o       <= 1'b1;
              rsp_fault_o      <= 1'b1;
              rsp_fault_code_o <= FLT_LENGTH;
              rsp_paddr_o      <= '0;
            end else begin
              state_q         <= ST_RD_OUTER;
              mem_req_valid_o <= 1'b1;
              mem_req_addr_o  <= outer_addr;
            end
          end
        end
        ST_RD_OUTER: begin
          if (mem_req_valid_o && mem_req_ready_i) begin
            mem_req_valid_o <= 1'b0;
          end else if (rsp_take) begin
            if (!ent_valid) begin
              state_q          <= ST_FAULT;
              rsp_done_o       <= 1'b1;
              rsp_fault_o      <= 1'b1;
              rsp_fault_code_o <= FLT_OUTER_INV;
              rsp_paddr_o      <= '0;
            end else begin
              state_q         <= ST_RD_INNER;
              mem_req_valid_o <= 1'b1;
              mem_req_addr_o  <= inner_addr;
            end
          end
        end
        ST_RD_INNER: begin
          if (mem_req_valid_o && mem_req_ready_i) begin
            mem_req_valid_o <= 1'b0;
          end else if (rsp_take) begin
            rsp_done_o <= 1'b1;
            if (!ent_valid || (write_q && !ent_writable)) begin
              state_q          <= ST_FAULT;
              rsp_fault_o      <= 1'b1;
              rsp_fault_code_o <= !ent_valid ? FLT_INNER_INV : FLT_PROTECT;
              rsp_paddr_o      <= '0;
            end else begin
              state_q          <= ST_DONE;
              rsp_fault_code_o <= '0;
              rsp_paddr_o      <= {ent_base, page_off};
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk #(
  parameter int OUT_W = 12,
  parameter int ENT_W = 32,
  parameter int LEN_W = OUT_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [ENT_W-1:0] ptbr_i,
  input logic [LEN_W-1:0] ptlr_i,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [OUT_W-1:0] req_outer_i,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic [ENT_W-1:0] mem_req_addr_o,
  input logic             rsp_done_o,
  input logic             rsp_fault_o,
  input logic [1:0]       rsp_fault_code_o
);
  logic accept;
  logic out_of_len;
  assign accept     = req_valid_i && req_ready_o;
  assign out_of_len = {1'b0, req_outer_i} >= ptlr_i;

  a_r3_len_trap: assert property (@(posedge clk) disable iff (rst)
    accept && out_of_len |=> rsp_done_o && rsp_fault_o &&
                             rsp_fault_code_o == 2'd0 && !mem_req_valid_o);

  a_r2_outer_addr: assert property (@(posedge clk) disable iff (rst)
    accept && !out_of_len |=> mem_req_valid_o &&
      mem_req_addr_o == $past(ptbr_i) + (ENT_W'($past(req_outer_i)) << 2));

  a_r9_hold_req: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done_o |=> !rsp_done_o);

  a_r8_fault_with_done: assert property (@(posedge clk) disable iff (rst)
    rsp_fault_o |-> rsp_done_o);

  a_r10_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid_o || rsp_done_o) |-> !req_ready_o);
endmodule

bind pgw_walker pgw_walker_chk #(.OUT_W(OUT_W), .ENT_W(ENT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .ptbr_i(ptbr_i), .ptlr_i(ptlr_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_outer_i(req_vaddr_i[VA_W-1 -: OUT_W]),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o(mem_req_addr_o), .rsp_done_o(rsp_done_o),
  .rsp_fault_o(rsp_fault_o), .rsp_fault_code_o(rsp_fault_code_o)
);

// File: tb/tb_pgw_walker.sv
module tb_pgw_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ROOT = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] ptbr = ROOT;
  logic [12:0] ptlr = 13'd16;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic rsp_done, rsp_fault;
  logic [1:0] rsp_code;
  logic [31:0] rsp_paddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgw_walker dut (
    .clk(clk), .rst(rst), .ptbr_i(ptbr), .ptlr_i(ptlr),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data), .rsp_done_o(rsp_done),
    .rsp_fault_o(rsp_fault), .rsp_fault_code_o(rsp_code), .rsp_paddr_o(rsp_paddr)
  );

  // memory model
  logic [31:0] mem [logic [31:0]];
  int lat = 1, stall = 0, stall_c = 0, wcnt = 0, nreads = 0;
  logic pend = 1'b0;
  logic [31:0] cap;
  logic [31:0] rlog [0:3];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (wcnt <= 1) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = rd(cap); pend = 1'b0;
      end else wcnt--;
    end
    if (mem_req_valid && !pend) begin
      if (stall_c > 0) begin stall_c--; mem_req_ready = 1'b0; end
      else begin
        mem_req_ready = 1'b1; pend = 1'b1; wcnt = lat; cap = mem_req_addr;
        if (nreads < 4) rlog[nreads] = mem_req_addr;
        nreads++; stall_c = stall;
      end
    end else mem_req_ready = 1'b0;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] va(input int o, input int i, input int d);
    return (32'(o) << 20) | (32'(i) << 10) | 32'(d);
  endfunction

  task automatic walk(input string tag, input logic [31:0] a, input logic wr,
                      input logic efault, input logic [1:0] ecode, input logic [31:0] epa,
                      input int ereads, input logic [31:0] ea0, input logic [31:0] ea1,
                      input bit intrude);
    int k = 0;
    @(negedge clk);
    nreads = 0; stall_c = stall;
    req_valid = 1'b1; req_vaddr = a; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude) begin
      chk({tag, " R10 ready low while busy"}, {31'b0, req_ready}, 32'd0);
      req_valid = 1'b1; req_vaddr = va(15, 0, 0); req_write = 1'b0;
      @(negedge clk); @(negedge clk);
      req_valid = 1'b0;
    end
    while (!rsp_done && k < 200) begin @(negedge clk); k++; end
    chk({tag, " done seen"}, {31'b0, rsp_done}, 32'd1);
    chk({tag, " fault flag"}, {31'b0, rsp_fault}, {31'b0, efault});
    if (efault) chk({tag, " fault code"}, {30'b0, rsp_code}, {30'b0, ecode});
    chk({tag, " paddr"}, rsp_paddr, epa);
    chk({tag, " read count"}, 32'(nreads), 32'(ereads));
    if (ereads > 0) chk({tag, " R2 outer read addr"}, rlog[0], ea0);
    if (ereads > 1) chk({tag, " R4 inner read addr"}, rlog[1], ea1);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, {31'b0, rsp_done}, 32'd0);
    chk({tag, " R10 ready after walk"}, {31'b0, req_ready}, 32'd1);
    if (intrude) begin
      repeat (4) @(negedge clk);
      chk({tag, " R10 dropped request"}, 32'(nreads), 32'(ereads));
    end
  endtask

  localparam logic [31:0] E_RW  = (32'h0ABC << 10) | 32'h3;
  localparam logic [31:0] E_RO  = (32'h0123 << 10) | 32'h1;
  localparam logic [31:0] E_HI  = (32'h07FF << 10) | 32'h3;

  task automatic t_reset();
    chk("R1 reset ready", {31'b0, req_ready}, 32'd1);
    chk("R1 reset mem req", {31'b0, mem_req_valid}, 32'd0);
    chk("R1 reset done", {31'b0, rsp_done}, 32'd0);
  endtask

  task automatic t_read_ok();
    lat = 1; stall = 0;
    walk("R8 read ok", va(3, 5, 'h2A7), 1'b0, 1'b0, 2'd0, (E_RW & ~32'h3FF) | 32'h2A7,
         2, ROOT + 12, 32'h2_0000 + 20, 1'b0);
  endtask

  task automatic t_slow();
    lat = 6; stall = 3;
    walk("R9 slow write ok", va(3, 5, 'h3FF), 1'b1, 1'b0, 2'd0, (E_RW & ~32'h3FF) | 32'h3FF,
         2, ROOT + 12, 32'h2_0000 + 20, 1'b0);
    lat = 1; stall = 0;
  endtask

  task automatic t_len();
    walk("R3 outer at bound", va(16, 0, 5), 1'b0, 1'b1, 2'd0, 32'h0, 0, 0, 0, 1'b0);
    walk("R3 outer below bound", va(15, 0, 'h011), 1'b0, 1'b0, 2'd0, (E_HI & ~32'h3FF) | 32'h011,
         2, ROOT + 60, 32'h4_0000, 1'b0);
    ptlr = 13'd0;
    walk("R3 zero bound", va(0, 0, 0), 1'b1, 1'b1, 2'd0, 32'h0, 0, 0, 0, 1'b0);
    ptlr = 13'd16;
  endtask

  task automatic t_outer_inv();
    walk("R5 outer invalid", va(4, 1, 1), 1'b0, 1'b1, 2'd1, 32'h0, 1, ROOT + 16, 0, 1'b0);
  endtask

  task automatic t_inner_inv();
    walk("R6 inner invalid write", va(3, 7, 2), 1'b1, 1'b1, 2'd2, 32'h0,
         2, ROOT + 12, 32'h2_0000 + 28, 1'b0);
  endtask

  task automatic t_prot();
    walk("R7 write read-only", va(3, 6, 9), 1'b1, 1'b1, 2'd3, 32'h0,
         2, ROOT + 12, 32'h2_0000 + 24, 1'b0);
    walk("R7 read read-only", va(3, 6, 9), 1'b0, 1'b0, 2'd0, (E_RO & ~32'h3FF) | 32'h9,
         2, ROOT + 12, 32'h2_0000 + 24, 1'b0);
  endtask

  task automatic t_busy();
    lat = 3;
    walk("R10 busy ignore", va(3, 5, 'h100), 1'b0, 1'b0, 2'd0, (E_RW & ~32'h3FF) | 32'h100,
         2, ROOT + 12, 32'h2_0000 + 20, 1'b1);
    lat = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    mem[ROOT + 12] = 32'h0002_0000 | 32'h1;
    mem[ROOT + 16] = 32'h0003_0000;
    mem[ROOT + 60] = 32'h0004_0000 | 32'h1;
    mem[32'h2_0000 + 20] = E_RW;
    mem[32'h2_0000 + 24] = E_RO;
    mem[32'h2_0000 + 28] = (32'h55 << 10) | 32'h2;
    mem[32'h4_0000] = E_HI;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_ok();
    t_slow();
    t_len();
    t_outer_inv();
    t_inner_inv();
    t_prot();
    t_busy();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule